// File: doc/BRIEF.md
# Flash Command Decoder with Unlock Bypass

This block turns a stream of bus write cycles into flash operation requests. Each write cycle carries an address and a data byte. A run of unlock cycles followed by a command byte produces a one-cycle request to program a word, erase one block or erase the whole chip. The array, the erase timing window and voltage sensing sit outside the block.

Software can switch the decoder into a sticky bypass mode. In that mode the unlock cycles are skipped, so program and erase each take two writes, and the mode is left only through a dedicated two-write exit. A level input stands in for the high-voltage pin. While that input is high the decoder is in bypass mode and ignores the block-protect vector. When it drops, the mode returns to whatever software last selected.

The block address is the top `BLK_W` bits of the write address. With the default parameters it is `wr_addr[15:13]`, so block 5 covers addresses A000h to BFFFh.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request is raised, `read_mode` is 1 and `bypass_mode` is 0.
- R2: In normal mode the four writes 555h/AAh, 2AAh/55h, 555h/A0h and then any address/data raise `prog_req` for one cycle after the fourth write. `req_addr` and `req_data` carry that address and data.
- R3: In normal mode the writes 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h and then data 30h at any address raise `erase_blk_req` with that address on `req_addr`. If the sixth write is 555h/10h instead, `erase_chip_req` is raised.
- R4: In normal mode, a write that does not match the expected address and data of the next step abandons the sequence. `read_mode` is 1 after it, and later writes must restart from the first unlock cycle.
- R5: The three writes 555h/AAh, 2AAh/55h, 555h/20h set `bypass_mode` to 1 and `read_mode` to 0.
- R6: In bypass mode, data A0h at any address followed by one address/data write raises `prog_req` with that address and data.
- R7: In bypass mode, data 80h followed by data 30h raises `erase_blk_req` with the address of the second write. Data 80h followed by data 10h raises `erase_chip_req`.
- R8: Bypass mode set by software ends only after data 90h is followed directly by data 00h, after which `bypass_mode` is 0 and `read_mode` is 1. Other data, including 90h followed by a value other than 00h, leaves `bypass_mode` at 1.
- R9: While `hw_bypass` is 1, `bypass_mode` is 1 and the two-write bypass commands work. When it returns to 0 without software having entered bypass, `bypass_mode` is 0 and `read_mode` is 1.
- R10: With `hw_bypass` 0, a program or block erase aimed at a block whose `protect` bit is 1 raises no request. A chip erase raises none if any `protect` bit is 1. With `hw_bypass` 1, protection is ignored.
- R11: Each request lasts exactly one cycle, and at most one of the three requests is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | A bus write cycle is present |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| hw_bypass | input | 1 | Level that forces bypass mode and disables protection |
| protect | input | 2**BLK_W | Per-block protect bits |
| prog_req | output | 1 | One-cycle program request |
| erase_blk_req | output | 1 | One-cycle block erase request |
| erase_chip_req | output | 1 | One-cycle chip erase request |
| req_addr | output | ADDR_W | Address attached to the request |
| req_data | output | 8 | Data attached to a program request |
| bypass_mode | output | 1 | Bypass mode active |
| read_mode | output | 1 | Normal mode with no command sequence in progress |

## Verification
A wrong sequence state shows up on the port side as a request that is missing or spurious in the cycle right after the final write. It can also show as `read_mode` failing to return to 1 after a mismatched write. A lost or stuck bypass flag appears at once on `bypass_mode`, and also as a two-write program that fails to issue. A protection error is visible as a request to a protected block, or as a request suppressed while `hw_bypass` is high. Every such error reaches the outputs one clock after the write that triggers it.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  hw_bypass,
  input  logic [(1<<BLK_W)-1:0] protect,
  output logic                  prog_req,
  output logic                  erase_blk_req,
  output logic                  erase_chip_req,
  output logic [ADDR_W-1:0]     req_addr,
  output logic [7:0]            req_data,
  output logic                  bypass_mode,
  output logic                  read_mode
);
  localparam logic [ADDR_W-1:0] A_UNLK1 = ADDR_W'('h555);
  localparam logic [ADDR_W-1:0] A_UNLK2 = ADDR_W'('h2AA);

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5, S_BPGM, S_BERS, S_BRST
  } st_t;

  st_t  state, cur, nxt;
  logic sw_bypass, set_sw, clr_sw;
  logic do_prog, do_blk, do_chip, st_ok, blk_open, chip_open;
  logic [BLK_W-1:0] blk;

  assign bypass_mode = sw_bypass | hw_bypass;
  assign st_ok = bypass_mode ? (state inside {S_BPGM, S_BERS, S_BRST})
                             : (state inside {S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5});
  assign cur       = st_ok ? state : S_IDLE;
  assign read_mode = !bypass_mode && (cur == S_IDLE);
  assign blk       = wr_addr[ADDR_W-1 -: BLK_W];
  assign blk_open  = hw_bypass || !protect[blk];
  assign chip_open = hw_bypass || (protect == '0);

  always_comb begin
    nxt = cur; set_sw = 1'b0; clr_sw = 1'b0;
    do_prog = 1'b0; do_blk = 1'b0; do_chip = 1'b0;
    if (wr_en) begin
      nxt = S_IDLE;
      if (bypass_mode) begin
        case (cur)
          S_BPGM: do_prog = 1'b1;
          S_BERS: begin
            do_blk  = (wr_data == 8'h30);
            do_chip = (wr_data == 8'h10);
          end
          S_BRST: clr_sw = (wr_data == 8'h00);
          default: begin
            if (wr_data == 8'hA0)      nxt = S_BPGM;
            else if (wr_data == 8'h80) nxt = S_BERS;
            else if (wr_data == 8'h90) nxt = S_BRST;
          end
        endcase
      end else begin
        case (cur)
          S_U1: if (wr_addr == A_UNLK2 && wr_data == 8'h55) nxt = S_U2;
          S_U2: if (wr_addr == A_UNLK1) begin
            if (wr_data == 8'hA0)      nxt = S_PGM;
            else if (wr_data == 8'h80) nxt = S_E3;
            else if (wr_data == 8'h20) set_sw = 1'b1;
          end
          S_PGM: do_prog = 1'b1;
          S_E3: if (wr_addr == A_UNLK1 && wr_data == 8'hAA) nxt = S_E4;
          S_E4: if (wr_addr == A_UNLK2 && wr_data == 8'h55) nxt = S_E5;
          S_E5: begin
            do_blk  = (wr_data == 8'h30);
            do_chip = (wr_data == 8'h10) && (wr_addr == A_UNLK1);
          end
          default: if (wr_addr == A_UNLK1 && wr_data == 8'hAA) nxt = S_U1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      sw_bypass      <= 1'b0;
      prog_req       <= 1'b0;
      erase_blk_req  <= 1'b0;
      erase_chip_req <= 1'b0;
      req_addr       <= '0;
      req_data       <= '0;
    end else begin
      state          <= nxt;
      if (set_sw) sw_bypass <= 1'b1;
      else if (clr_sw) sw_bypass <= 1'b0;
      prog_req       <= do_prog && blk_open;
      erase_blk_req  <= do_blk && blk_open;
      erase_chip_req <= do_chip && chip_open;
      if (do_prog || do_blk || do_chip) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [7:0]            wr_data,
  input logic                  hw_bypass,
  input logic [(1<<BLK_W)-1:0] protect,
  input logic                  prog_req,
  input logic                  erase_blk_req,
  input logic                  erase_chip_req,
  input logic [ADDR_W-1:0]     req_addr,
  input logic [7:0]            req_data,
  input logic                  bypass_mode,
  input logic                  read_mode
);
  logic [(1<<BLK_W)-1:0] prot_q;
  logic hw_q;
  logic [BLK_W-1:0] req_blk;
  logic any_req;

  assign req_blk = req_addr[ADDR_W-1 -: BLK_W];
  assign any_req = prog_req | erase_blk_req | erase_chip_req;

  always_ff @(posedge clk) begin
    prot_q <= protect;
    hw_q   <= hw_bypass;
  end

  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, erase_blk_req, erase_chip_req}));
  a_r11_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  a_r11_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_blk_req || erase_chip_req) |=> !(erase_blk_req || erase_chip_req));
  a_r2_req_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> $past(wr_en));
  a_r10_blk_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || erase_blk_req) |-> (hw_q || !prot_q[req_blk]));
  a_r10_chip_protect: assert property (@(posedge clk) disable iff (!rst_n)
    erase_chip_req |-> (hw_q || prot_q == '0));
  a_r5_entry_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bypass_mode) && !hw_bypass) |-> $past(wr_en && wr_data == 8'h20));
  a_r8_exit_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bypass_mode) && !$past(hw_bypass)) |-> $past(wr_en && wr_data == 8'h00));
  a_r4_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (read_mode && !wr_en) |=> !any_req);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .hw_bypass(hw_bypass), .protect(protect), .prog_req(prog_req),
  .erase_blk_req(erase_blk_req), .erase_chip_req(erase_chip_req),
  .req_addr(req_addr), .req_data(req_data), .bypass_mode(bypass_mode),
  .read_mode(read_mode));

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        hw_bypass = 1'b0;
  logic [7:0]  protect = '0;
  logic        prog_req, erase_blk_req, erase_chip_req, bypass_mode, read_mode;
  logic [15:0] req_addr;
  logic [7:0]  req_data;

  int n_chk = 0;
  int n_fail = 0;
  logic pr, eb, ec, bm, rm;
  logic [15:0] ra;
  logic [7:0]  rd;

  always #2 clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hw_bypass(hw_bypass), .protect(protect), .prog_req(prog_req),
    .erase_blk_req(erase_blk_req), .erase_chip_req(erase_chip_req),
    .req_addr(req_addr), .req_data(req_data), .bypass_mode(bypass_mode),
    .read_mode(read_mode));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cap();
    pr = prog_req; eb = erase_blk_req; ec = erase_chip_req;
    ra = req_addr; rd = req_data; bm = bypass_mode; rm = read_mode;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; cap();
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h555, 8'hAA); wr(16'h2AA, 8'h55);
  endtask

  task automatic t_reset();
    cap();
    chk(rm == 1'b1, "R1", "read_mode", 32'(rm), 32'd1);
    chk(bm == 1'b0, "R1", "bypass_mode", 32'(bm), 32'd0);
    chk({pr, eb, ec} == 3'b000, "R1", "requests", 32'({pr, eb, ec}), 32'd0);
  endtask

  task automatic t_std_prog();
    wr(16'h555, 8'hAA);
    chk(rm == 1'b0, "R2", "read_mode mid sequence", 32'(rm), 32'd0);
    wr(16'h2AA, 8'h55); wr(16'h555, 8'hA0);
    chk(pr == 1'b0, "R2", "no early prog", 32'(pr), 32'd0);
    wr(16'h1234, 8'h5A);
    chk(pr == 1'b1, "R2", "prog_req", 32'(pr), 32'd1);
    chk(ra == 16'h1234, "R2", "req_addr", 32'(ra), 32'h1234);
    chk(rd == 8'h5A, "R2", "req_data", 32'(rd), 32'h5A);
    chk(rm == 1'b1, "R2", "back to read", 32'(rm), 32'd1);
    @(posedge clk); #1;
    chk(prog_req == 1'b0, "R11", "prog pulse one cycle", 32'(prog_req), 32'd0);
  endtask

  task automatic t_std_erase();
    unlock(); wr(16'h555, 8'h80); unlock(); wr(16'h4000, 8'h30);
    chk(eb == 1'b1 && ec == 1'b0, "R3", "block erase req", 32'({eb, ec}), 32'b10);
    chk(ra == 16'h4000, "R3", "block erase addr", 32'(ra), 32'h4000);
    @(posedge clk); #1;
    chk(erase_blk_req == 1'b0, "R11", "erase pulse one cycle", 32'(erase_blk_req), 32'd0);
    unlock(); wr(16'h555, 8'h80); unlock(); wr(16'h555, 8'h10);
    chk(ec == 1'b1 && eb == 1'b0 && pr == 1'b0, "R3", "chip erase req",
        32'({pr, eb, ec}), 32'b001);
  endtask

  task automatic t_mismatch();
    wr(16'h555, 8'hAA); wr(16'h2AA, 8'h66);
    chk(rm == 1'b1, "R4", "read after bad data", 32'(rm), 32'd1);
    wr(16'h555, 8'hA0); wr(16'h1000, 8'h11);
    chk(pr == 1'b0, "R4", "no prog after abort", 32'(pr), 32'd0);
    wr(16'h556, 8'hAA);
    chk(rm == 1'b1, "R4", "wrong unlock address", 32'(rm), 32'd1);
    unlock(); wr(16'h555, 8'h80); wr(16'h555, 8'hAB);
    chk(rm == 1'b1, "R4", "erase abort", 32'(rm), 32'd1);
  endtask

  task automatic t_protect();
    protect = 8'b0010_0000;
    unlock(); wr(16'h555, 8'hA0); wr(16'hA010, 8'h01);
    chk(pr == 1'b0, "R10", "prog to protected block", 32'(pr), 32'd0);
    unlock(); wr(16'h555, 8'hA0); wr(16'h2010, 8'h02);
    chk(pr == 1'b1, "R10", "prog to open block", 32'(pr), 32'd1);
    unlock(); wr(16'h555, 8'h80); unlock(); wr(16'hA000, 8'h30);
    chk(eb == 1'b0, "R10", "erase protected block", 32'(eb), 32'd0);
    unlock(); wr(16'h555, 8'h80); unlock(); wr(16'h555, 8'h10);
    chk(ec == 1'b0, "R10", "chip erase with protection", 32'(ec), 32'd0);
    protect = '0;
  endtask

  task automatic t_bypass();
    unlock(); wr(16'h555, 8'h20);
    chk(bm == 1'b1 && rm == 1'b0, "R5", "bypass entered", 32'({bm, rm}), 32'b10);
    wr(16'h0000, 8'hA0); wr(16'h3000, 8'h77);
    chk(pr == 1'b1 && ra == 16'h3000 && rd == 8'h77, "R6", "bypass prog",
        {8'(pr), ra, rd}, {8'd1, 16'h3000, 8'h77});
    wr(16'h0000, 8'h80); wr(16'h6000, 8'h30);
    chk(eb == 1'b1 && ra == 16'h6000, "R7", "bypass block erase",
        {15'd0, eb, ra}, {15'd0, 1'b1, 16'h6000});
    wr(16'h0000, 8'h80); wr(16'h0000, 8'h10);
    chk(ec == 1'b1, "R7", "bypass chip erase", 32'(ec), 32'd1);
    wr(16'h555, 8'hF0);
    chk(bm == 1'b1, "R8", "other data keeps bypass", 32'(bm), 32'd1);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h12);
    chk(bm == 1'b1, "R8", "90 then non-zero keeps bypass", 32'(bm), 32'd1);
    wr(16'h0000, 8'h90); wr(16'h0000, 8'h00);
    chk(bm == 1'b0 && rm == 1'b1, "R8", "exit sequence", 32'({bm, rm}), 32'b01);
  endtask

  task automatic t_hw();
    protect = 8'b0010_0000;
    @(negedge clk); hw_bypass = 1'b1; #1;
    chk(bypass_mode == 1'b1, "R9", "pin forces bypass", 32'(bypass_mode), 32'd1);
    wr(16'h0000, 8'hA0); wr(16'hA010, 8'h33);
    chk(pr == 1'b1 && ra == 16'hA010, "R9", "prog to protected block under pin",
        {15'd0, pr, ra}, {15'd0, 1'b1, 16'hA010});
    wr(16'h0000, 8'h80); wr(16'h0000, 8'h10);
    chk(ec == 1'b1, "R10", "chip erase ignores protection under pin", 32'(ec), 32'd1);
    @(negedge clk); hw_bypass = 1'b0; #1;
    chk(bypass_mode == 1'b0 && read_mode == 1'b1, "R9", "pin released",
        32'({bypass_mode, read_mode}), 32'b01);
    protect = '0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_std_prog();
    t_std_erase();
    t_mismatch();
    t_protect();
    t_bypass();
    t_hw();
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule